// File: doc/BRIEF.md
# Repeated String Compare Sequencer

This block walks two operand strings in memory and compares them one element at a time. A start strobe loads a source pointer, a destination pointer, an element count, an element size (byte or word), a direction and a termination mode. For each element the block fetches the source operand and then the destination operand over a byte-wide read port with a ready handshake. After the compare it moves both pointers, decrements the count and records equality in a zero flag.

The loop ends when the count reaches zero. In stop-on-mismatch mode it also ends at the first unequal pair. When the loop ends, the block shows the updated pointers, the remaining count and the zero flag, and pulses done for one cycle. A surrounding execution unit uses these values as its new register state.

Top module: `rep_str_cmp`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req` and `zf_o` are 0 and the pointer and count outputs are 0.
- R2: Each element is read source first and then destination. A byte element reads only the pointer address. A word element reads the low byte at the pointer and then the high byte at pointer+1. A read is accepted in a cycle with `mem_req` and `mem_ready` both high, and `mem_addr` stays unchanged while a request waits for ready. `mem_req` is 0 while the block is idle.
- R3: After each element both pointers change by 1 for bytes (`word_i`=0) or 2 for words (`word_i`=1). They increase when `down_i`=0 and decrease when `down_i`=1.
- R4: The count drops by exactly 1 per element compared, and the loop ends when it reaches zero.
- R5: With `until_ne_i`=1, a pair that differs ends the loop. The count has already been decremented and the pointers already moved for that element.
- R6: `zf_o` is 1 when the last compared pair was equal and 0 when it differed. A word compares all 16 bits.
- R7: A start with a count of zero makes no memory read, leaves `zf_o` unchanged and raises `done_o` in the cycle right after the start is sampled.
- R8: `done_o` is high for exactly one cycle per run, and a start pulse while `busy_o` is high is ignored.
- R9: With `until_ne_i`=0, a mismatch does not end the loop, and all elements are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| src_i | input | AW | Initial source pointer |
| dst_i | input | AW | Initial destination pointer |
| count_i | input | CW | Number of elements |
| word_i | input | 1 | 1 = word elements, 0 = byte elements |
| down_i | input | 1 | 1 = pointers decrease, 0 = increase |
| until_ne_i | input | 1 | 1 = stop at first mismatch |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_rdata | input | 8 | Read data, valid when ready |
| mem_ready | input | 1 | Read completes this cycle |
| src_o | output | AW | Current/final source pointer |
| dst_o | output | AW | Current/final destination pointer |
| count_o | output | CW | Current/final count |
| zf_o | output | 1 | Equality of last compared pair |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Two exit conditions can be met on the same element: the count reaching zero and a mismatch in stop-on-mismatch mode. Both then decide termination on the same edge. The bench provokes this by corrupting only the final element of a run. The outcome is judged by a count of zero, a cleared zero flag, pointers moved over the full length and a single done pulse. A separate run corrupts an early element, so a mismatch exit with a nonzero remaining count is also judged.

// File: rtl/rep_str_cmp.sv
module rep_str_cmp #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] count_i,
  input  logic          word_i,
  input  logic          down_i,
  input  logic          until_ne_i,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] count_o,
  output logic          zf_o,
  output logic          busy_o,
  output logic          done_o
);

  typedef enum logic [2:0] {S_IDLE, S_SL, S_SH, S_DL, S_DH, S_FIN} st_t;

  st_t           st;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          zf_q, word_q, down_q, ne_q;
  logic [15:0]   sbuf;
  logic [7:0]    dlo;

  logic [AW-1:0] step, src_nx, dst_nx;
  logic [CW-1:0] cnt_m1;
  logic [15:0]   sval, dval;
  logic          eq, elem_done, stop;

  assign step   = word_q ? AW'(2) : AW'(1);
  assign src_nx = down_q ? src_q - step : src_q + step;
  assign dst_nx = down_q ? dst_q - step : dst_q + step;
  assign cnt_m1 = cnt_q - CW'(1);

  assign sval = word_q ? sbuf : {8'h00, sbuf[7:0]};
  assign dval = word_q ? {mem_rdata, dlo} : {8'h00, mem_rdata};
  assign eq   = (sval == dval);

  assign elem_done = mem_ready && ((st == S_DL && !word_q) || st == S_DH);
  assign stop      = (cnt_m1 == '0) || (ne_q && !eq);

  assign mem_req = (st == S_SL) || (st == S_SH) || (st == S_DL) || (st == S_DH);

  always_comb begin
    case (st)
      S_SH:    mem_addr = src_q + AW'(1);
      S_DL:    mem_addr = dst_q;
      S_DH:    mem_addr = dst_q + AW'(1);
      default: mem_addr = src_q;
    endcase
  end

  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign count_o = cnt_q;
  assign zf_o    = zf_q;
  assign busy_o  = (st != S_IDLE);
  assign done_o  = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      zf_q   <= 1'b0;
      word_q <= 1'b0;
      down_q <= 1'b0;
      ne_q   <= 1'b0;
      sbuf   <= '0;
      dlo    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          src_q  <= src_i;
          dst_q  <= dst_i;
          cnt_q  <= count_i;
          word_q <= word_i;
          down_q <= down_i;
          ne_q   <= until_ne_i;
          st     <= (count_i == '0) ? S_FIN : S_SL;
        end
        S_SL: if (mem_ready) begin
          sbuf[7:0] <= mem_rdata;
          st        <= word_q ? S_SH : S_DL;
        end
        S_SH: if (mem_ready) begin
          sbuf[15:8] <= mem_rdata;
          st         <= S_DL;
        end
        S_DL: if (mem_ready && word_q) begin
          dlo <= mem_rdata;
          st  <= S_DH;
        end
        S_FIN:   st <= S_IDLE;
        default: ;
      endcase
      if (elem_done) begin
        zf_q  <= eq;
        cnt_q <= cnt_m1;
        src_q <= src_nx;
        dst_q <= dst_nx;
        st    <= stop ? S_FIN : S_SL;
      end
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done && !down_q && !word_q |=> src_q == $past(src_q) + AW'(1)); // R3
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> cnt_q == $past(cnt_q) - CW'(1)); // R4
  AST_NE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done && ne_q && !eq |=> done_o && !zf_o); // R5
  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start && count_i == '0 |=> done_o && !mem_req && $stable(zf_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

endmodule

// File: tb/rep_str_cmp_test.sv
module rep_str_cmp_test;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] src_i = 0, dst_i = 0, count_i = 0;
  logic        word_i = 0, down_i = 0, until_ne_i = 0;
  logic        mem_req, mem_ready = 1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] src_o, dst_o, count_o;
  logic        zf_o, busy_o, done_o;

  rep_str_cmp #(.AW(16), .CW(16)) uut (.*);

  always #2.5 clk = ~clk;

  logic [7:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  int checks = 0, fails = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [15:0] addr_q[$];
  logic [15:0] es_q[$], ed_q[$], ec_q[$];
  bit          ez_q[$];
  string       tag_q[$];
  bit          zf_model = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_ready) begin
      if (addr_q.size() == 0) chk(0, "R2 unexpected read", mem_addr, 0);
      else begin
        logic [15:0] ea;
        ea = addr_q.pop_front();
        chk(mem_addr == ea, "R2 read address", mem_addr, ea);
      end
    end
    if (done_o) begin
      if (es_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
      else begin
        logic [15:0] s, d, c; bit z; string t;
        s = es_q.pop_front(); d = ed_q.pop_front(); c = ec_q.pop_front();
        z = ez_q.pop_front(); t = tag_q.pop_front();
        chk(src_o == s, {t, " src ptr"}, src_o, s);
        chk(dst_o == d, {t, " dst ptr"}, dst_o, d);
        chk(count_o == c, {t, " count"}, count_o, c);
        chk(zf_o == z, {t, " zf"}, zf_o, z);
      end
    end
  end

  function automatic logic [15:0] rd(input logic [15:0] a, input bit w);
    rd = w ? {mem[8'(a + 16'd1)], mem[a[7:0]]} : {8'h00, mem[a[7:0]]};
  endfunction

  task automatic fill(input logic [15:0] s, d, n, input bit w, dn, input int bad);
    logic [15:0] st = w ? 16'd2 : 16'd1;
    for (int i = 0; i < int'(n); i++) begin
      mem[s[7:0]] = 8'(s * 13 + 7);
      mem[d[7:0]] = mem[s[7:0]];
      if (w) begin
        mem[8'(s + 16'd1)] = 8'(s * 5 + 1);
        mem[8'(d + 16'd1)] = mem[8'(s + 16'd1)];
      end
      if (i == bad) begin
        if (w) mem[8'(d + 16'd1)] = mem[8'(d + 16'd1)] ^ 8'h40;
        else   mem[d[7:0]] = mem[d[7:0]] ^ 8'h01;
      end
      s = dn ? s - st : s + st;
      d = dn ? d - st : d + st;
    end
  endtask

  task automatic run(input logic [15:0] s, d, n, input bit w, dn, ne, poke, input string tag);
    logic [15:0] cs = s, cd = d, cn = n, st = w ? 16'd2 : 16'd1;
    bit z = zf_model, eq;
    while (cn != 0) begin
      addr_q.push_back(cs); if (w) addr_q.push_back(cs + 16'd1);
      addr_q.push_back(cd); if (w) addr_q.push_back(cd + 16'd1);
      eq = rd(cs, w) == rd(cd, w);
      z = eq; cn--;
      cs = dn ? cs - st : cs + st;
      cd = dn ? cd - st : cd + st;
      if (ne && !eq) break;
    end
    es_q.push_back(cs); ed_q.push_back(cd); ec_q.push_back(cn);
    ez_q.push_back(z); tag_q.push_back(tag);
    zf_model = z;
    @(negedge clk);
    src_i = s; dst_i = d; count_i = n; word_i = w; down_i = dn; until_ne_i = ne; start = 1;
    @(negedge clk);
    start = 0;
    if (n == 0) chk(done_o == 1, "R7 done one cycle after start", done_o, 1);
    if (poke) begin
      @(negedge clk);
      src_i = 16'h00F0; dst_i = 16'h00F8; count_i = 0; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk(done_o == 0, "R8 done single cycle", done_o, 0);
    chk(addr_q.size() == 0, "R2 all reads made", addr_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 3);
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && mem_req == 0, "R1 control idle", {busy_o, done_o, mem_req}, 0);
    chk(zf_o == 0 && src_o == 0 && dst_o == 0 && count_o == 0, "R1 state zero", {zf_o, src_o, dst_o, count_o}, 0);
    rst_n = 1;

    fill(16'h0020, 16'h0060, 4, 0, 0, -1);
    run(16'h0020, 16'h0060, 4, 0, 0, 1, 0, "R3 R4 R6 byte up equal");

    fill(16'h0010, 16'h0050, 5, 1, 0, 1);
    run(16'h0010, 16'h0050, 5, 1, 0, 1, 0, "R5 R6 word up early mismatch");

    fill(16'h0038, 16'h0078, 3, 0, 1, 1);
    run(16'h0038, 16'h0078, 3, 0, 1, 0, 0, "R9 byte down continue");

    stall_en = 1;
    fill(16'h00A0, 16'h00D0, 4, 1, 1, -1);
    run(16'h00A0, 16'h00D0, 4, 1, 1, 1, 0, "R2 R3 word down stalled");

    fill(16'h0090, 16'h00C0, 3, 1, 0, 2);
    run(16'h0090, 16'h00C0, 3, 1, 0, 1, 0, "R4 R5 mismatch on last");
    stall_en = 0;

    run(16'h0044, 16'h0088, 0, 1, 0, 1, 0, "R7 zero count");

    fill(16'h0020, 16'h0060, 6, 0, 0, -1);
    run(16'h0020, 16'h0060, 6, 0, 0, 1, 1, "R8 start while busy");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule